// File: doc/BRIEF.md
# Page-Mode Memory Read Sequencer

This block runs read transfers against an external asynchronous memory that supports page reads, such as a burst flash or a ROM. A host presents a byte address and a byte-enable mask through a valid/ready pair. The block drives the memory address bus, an active-low chip select, an active-low read strobe and active-low byte selects. It samples the memory data bus when each access ends and returns the word with a one-cycle done strobe.

Each access is timed by one of two programmable pulse counts. Opening a page costs the long page-access count. A read that follows without a break and stays inside the open page costs the short in-page count. Chip select and read strobe stay low across the whole chain of back-to-back reads. Only the offset bits of the address move between hits inside a page. A break in the request stream closes the page, so the next read pays the long count again.

Top module: `pmrd_seq`

## Requirements
- R1: While reset is applied and right after it is released, `mem_cs_n`, `mem_rd_n` and every bit of `mem_bs_n` are 1, `rd_done` is 0 and `req_ready` is 1.
- R2: `mem_rd_n` equals `mem_cs_n` on every cycle. Both fall and rise on the same clock edge.
- R3: Across a chain of requests with no idle cycle between them, chip select stays low with no gap. It returns high only in the cycle after an access whose last cycle saw no pending request.
- R4: An access that opens a page keeps the strobes asserted for `cfg_first_pulse` cycles.
- R5: An access that hits the open page lasts `cfg_page_pulse` cycles.
- R6: The two counts are applied as programmed even when `cfg_first_pulse` is smaller than `cfg_page_pulse`. No consistency adjustment is made.
- R7: A pulse count of 0 gives an access of exactly 1 cycle.
- R8: A request is a page hit only when it is accepted in the last cycle of an ongoing access and its address bits above bit `PAGE_OFS_W-1` equal those of the open page. A mismatch, or any request accepted from idle, opens a new page.
- R9: `rd_data` holds the value of `mem_data` sampled at the clock edge that ends the access. `rd_done` is 1 for the cycle that follows that edge, with one pulse per access.
- R10: With `cfg_bat` = 0, `mem_bs_n` is the bitwise inverse of the request's `req_be` (bit i selects byte lane i). With `cfg_bat` = 1, all byte selects are low. The value is held for the whole access, and all byte selects are high while chip select is high.
- R11: `mem_addr` equals the accepted request address for the whole access. On a page hit, the bits above the page offset do not change.
- R12: `req_ready` is 1 only while idle or in the last cycle of an access. A request is accepted on a clock edge where both `req_valid` and `req_ready` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_first_pulse | input | CNT_W | Page-opening access length in cycles |
| cfg_page_pulse | input | CNT_W | In-page access length in cycles |
| cfg_bat | input | 1 | Byte select mode: 0 = from byte enables, 1 = all selected |
| req_valid | input | 1 | Host read request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | ADDR_W | Request byte address |
| req_be | input | DATA_W/8 | Request byte enables |
| rd_data | output | DATA_W | Returned read data |
| rd_done | output | 1 | One-cycle strobe, `rd_data` valid |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_bs_n | output | DATA_W/8 | Active-low byte selects |
| mem_data | input | DATA_W | Memory data bus |

## Verification
Some rules are checked by assertions on every cycle:
- chip select rises only after a final access cycle with no request pending;
- byte selects are released whenever chip select is high;
- the page bits of the address stay fixed across a hit;
- the done strobe follows only an asserted strobe;
- ready is held low inside an access;
- a loaded counter is never zero;
- a closed page is really invalidated.

Other properties only show in the bench's scenarios. These are the exact cycle count of each access for a page open versus a page hit, the inverted-order pulse setting, the zero count, the treatment of idle gaps, and the data returned for each address.

// File: rtl/pmrd_pkg.sv
package pmrd_pkg;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } pmrd_state_e;

endpackage

// File: rtl/pmrd_pulse_timer.sv
module pmrd_pulse_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      // a zero count still yields a one-cycle access
      cnt_d = (load_val == '0) ? CNT_W'(1) : load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == CNT_W'(1));

  // R7: every loaded access runs at least one cycle
  a_r7_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q != '0));

endmodule

// File: rtl/pmrd_page_tracker.sv
module pmrd_page_tracker #(
  parameter int ADDR_W     = 24,
  parameter int PAGE_OFS_W = 4,
  localparam int TAG_W     = ADDR_W - PAGE_OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_en,
  input  logic              close,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit
);

  logic [TAG_W-1:0] tag_q;
  logic [TAG_W-1:0] tag_d;
  logic             valid_q;
  logic             valid_d;

  always_comb begin
    tag_d   = tag_q;
    valid_d = valid_q;
    if (open_en) begin
      tag_d   = req_addr[ADDR_W-1:PAGE_OFS_W];
      valid_d = 1'b1;
    end else if (close) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      tag_q   <= tag_d;
      valid_q <= valid_d;
    end
  end

  assign hit = valid_q && (req_addr[ADDR_W-1:PAGE_OFS_W] == tag_q);

  // R8: a page left by an idle gap never reports a hit
  a_r8_close_drops_page: assert property (@(posedge clk) disable iff (!rst_n)
    (close && !open_en) |=> !valid_q);

endmodule

// File: rtl/pmrd_seq.sv
module pmrd_seq #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int PAGE_OFS_W = 4,
  parameter int CNT_W      = 6,
  localparam int BE_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_first_pulse,
  input  logic [CNT_W-1:0]  cfg_page_pulse,
  input  logic              cfg_bat,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_rd_n,
  output logic [BE_W-1:0]   mem_bs_n,
  input  logic [DATA_W-1:0] mem_data
);
  import pmrd_pkg::*;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_pipe_q[1];

  pmrd_state_e       state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [BE_W-1:0]   bs_n_q, bs_n_d;
  logic              cs_n_q, rd_n_q, strobe_n_d;
  logic [DATA_W-1:0] data_q;
  logic              done_q, done_d;
  logic              cap_en;
  logic              accept;
  logic              last;
  logic              hit;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              page_open;
  logic              page_close;

  pmrd_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (load),
    .load_val (load_val),
    .last     (last)
  );

  pmrd_page_tracker #(.ADDR_W(ADDR_W), .PAGE_OFS_W(PAGE_OFS_W)) u_page (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .open_en  (page_open),
    .close    (page_close),
    .req_addr (req_addr),
    .hit      (hit)
  );

  assign req_ready = (state_q == ST_IDLE) || last;
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d    = state_q;
    addr_d     = addr_q;
    bs_n_d     = bs_n_q;
    strobe_n_d = cs_n_q;
    load       = 1'b0;
    load_val   = cfg_first_pulse;
    page_open  = 1'b0;
    page_close = 1'b0;
    done_d     = 1'b0;
    cap_en     = 1'b0;
    if ((state_q == ST_ACCESS) && last) begin
      done_d = 1'b1;
      cap_en = 1'b1;
    end
    if (accept) begin
      state_d    = ST_ACCESS;
      addr_d     = req_addr;
      bs_n_d     = cfg_bat ? '0 : ~req_be;
      strobe_n_d = 1'b0;
      load       = 1'b1;
      load_val   = ((state_q == ST_ACCESS) && hit) ? cfg_page_pulse : cfg_first_pulse;
      page_open  = 1'b1;
    end else if ((state_q == ST_ACCESS) && last) begin
      state_d    = ST_IDLE;
      bs_n_d     = '1;
      strobe_n_d = 1'b1;
      page_close = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      bs_n_q  <= '1;
      cs_n_q  <= 1'b1;
      rd_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      bs_n_q  <= bs_n_d;
      cs_n_q  <= strobe_n_d;
      rd_n_q  <= strobe_n_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      data_q <= '0;
    end else if (cap_en) begin
      data_q <= mem_data;
    end
  end

  assign mem_addr = addr_q;
  assign mem_cs_n = cs_n_q;
  assign mem_rd_n = rd_n_q;
  assign mem_bs_n = bs_n_q;
  assign rd_data  = data_q;
  assign rd_done  = done_q;

  // R3: the strobes are released only after a final cycle with nothing pending
  a_r3_release_at_end: assert property (@(posedge clk) disable iff (!rst_n_int)
    $rose(mem_cs_n) |-> $past(last && !req_valid));

  // R10: byte selects are released outside an access
  a_r10_bs_idle: assert property (@(posedge clk) disable iff (!rst_n_int)
    mem_cs_n |-> (mem_bs_n == '1));

  // R11: a page hit keeps the page bits of the address
  a_r11_page_bits_stable: assert property (@(posedge clk) disable iff (!rst_n_int)
    (accept && hit && (state_q == ST_ACCESS)) |=>
      (mem_addr[ADDR_W-1:PAGE_OFS_W] == $past(mem_addr[ADDR_W-1:PAGE_OFS_W])));

  // R9: done only follows an asserted strobe
  a_r9_done_after_strobe: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_done |-> $past(!mem_cs_n));

  // R12: no acceptance before the final cycle of an access
  a_r12_ready_blocked: assert property (@(posedge clk) disable iff (!rst_n_int)
    (!mem_cs_n && !last) |-> !req_ready);

endmodule

// File: tb/pmrd_seq_bench.sv
`timescale 1ns/1ps
module pmrd_seq_bench;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int BW = 2;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] cfg_first_pulse;
  logic [CW-1:0] cfg_page_pulse;
  logic          cfg_bat;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [BW-1:0] req_be;
  logic [DW-1:0] rd_data;
  logic          rd_done;
  logic [AW-1:0] mem_addr;
  logic          mem_cs_n;
  logic          mem_rd_n;
  logic [BW-1:0] mem_bs_n;
  logic [DW-1:0] mem_data;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] mem_val(logic [AW-1:0] a);
    return {a[7:0] ^ 8'hA5, a[15:8] ^ a[23:16]};
  endfunction

  assign mem_data = (!mem_cs_n && !mem_rd_n) ? mem_val(mem_addr) : 16'hDEAD;

  pmrd_seq u_pmrd_seq (
    .clk(clk), .rst_n(rst_n),
    .cfg_first_pulse(cfg_first_pulse), .cfg_page_pulse(cfg_page_pulse),
    .cfg_bat(cfg_bat),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_be(req_be),
    .rd_data(rd_data), .rd_done(rd_done),
    .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_rd_n(mem_rd_n),
    .mem_bs_n(mem_bs_n), .mem_data(mem_data)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // expected-access queue
  logic [AW-1:0] q_addr [256];
  logic [BW-1:0] q_bs   [256];
  int            q_len  [256];
  bit            q_chain[256];
  bit            q_hit  [256];
  logic [7:0]    wr_ptr = '0;
  logic [7:0]    rd_ptr = '0;
  logic [AW-1:0] prev_addr;
  string         scen = "R1";
  bit            mon_en = 1'b0;
  bit            r2_bad = 1'b0;
  int            low_cnt = 0;
  int            tot_cnt = 0;
  bit            addr_bad = 1'b0;
  bit            bs_bad = 1'b0;

  function automatic int clamp(logic [CW-1:0] v);
    return (v == '0) ? 1 : int'(v);
  endfunction

  task automatic send_req(input logic [AW-1:0] a, input logic [BW-1:0] be, input bit chained);
    bit hitx;
    bit rdy;
    hitx = chained && (a[AW-1:4] == prev_addr[AW-1:4]);
    q_addr[wr_ptr]  = a;
    q_bs[wr_ptr]    = cfg_bat ? '0 : ~be;
    q_len[wr_ptr]   = hitx ? clamp(cfg_page_pulse) : clamp(cfg_first_pulse);
    q_chain[wr_ptr] = chained;
    q_hit[wr_ptr]   = hitx;
    prev_addr = a;
    @(negedge clk);
    wr_ptr++;
    req_valid = 1'b1;
    req_addr  = a;
    req_be    = be;
    forever begin
      rdy = req_ready;
      @(posedge clk);
      if (rdy) break;
      @(negedge clk);
    end
  endtask

  task automatic end_burst();
    @(negedge clk);
    req_valid = 1'b0;
    while (rd_ptr != wr_ptr) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: samples shortly after the falling edge
  always @(negedge clk) begin
    #1;
    if (mon_en) begin
      if (mem_cs_n !== mem_rd_n) r2_bad = 1'b1;
      if (rd_done) begin
        if (rd_ptr == wr_ptr) begin
          chk(1'b0, "R9 unexpected done", 1, 0);
        end else begin
          chk(rd_data == mem_val(q_addr[rd_ptr]), {"R9 data ", scen}, rd_data, mem_val(q_addr[rd_ptr]));
          chk(low_cnt == q_len[rd_ptr], {q_hit[rd_ptr] ? "R5" : "R4", " length ", scen},
              low_cnt, q_len[rd_ptr]);
          if (q_chain[rd_ptr]) chk(tot_cnt == q_len[rd_ptr], {"R3 no gap ", scen}, tot_cnt, q_len[rd_ptr]);
          chk(!addr_bad, {"R11 address held ", scen}, addr_bad, 0);
          chk(!bs_bad, {"R10 byte selects ", scen}, bs_bad, 0);
          rd_ptr++;
          low_cnt = 0; tot_cnt = 0; addr_bad = 1'b0; bs_bad = 1'b0;
          if ((rd_ptr == wr_ptr) && !req_valid) chk(mem_cs_n == 1'b1, "R3 release", mem_cs_n, 1);
        end
      end
      tot_cnt++;
      if (!mem_cs_n) begin
        low_cnt++;
        if (rd_ptr != wr_ptr) begin
          if (mem_addr != q_addr[rd_ptr]) addr_bad = 1'b1;
          if (mem_bs_n != q_bs[rd_ptr]) bs_bad = 1'b1;
        end
      end
    end
  end

  task automatic set_cfg(input int f, input int p, input bit b);
    cfg_first_pulse = CW'(f);
    cfg_page_pulse  = CW'(p);
    cfg_bat         = b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_addr = '0;
    req_be = '0;
    prev_addr = '0;
    set_cfg(4, 2, 1'b0);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_cs_n && mem_rd_n && (mem_bs_n == '1) && !rd_done && req_ready, "R1 in reset",
        {mem_cs_n, mem_rd_n, mem_bs_n, rd_done, req_ready}, 6'b111101);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem_cs_n && mem_rd_n && (mem_bs_n == '1) && !rd_done && req_ready, "R1 after release",
        {mem_cs_n, mem_rd_n, mem_bs_n, rd_done, req_ready}, 6'b111101);
    mon_en = 1'b1;

    // R4 R5 R11: one page, chained hits
    scen = "R5 hits";
    send_req(24'h001230, 2'b11, 0);
    send_req(24'h001232, 2'b01, 1);
    send_req(24'h00123E, 2'b10, 1);
    end_burst();

    // R12: ready stays low inside a long access
    scen = "R12";
    set_cfg(5, 2, 1'b0);
    send_req(24'h004000, 2'b11, 0);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr = 24'h004002;
    #1;
    chk(req_ready == 1'b0, "R12 ready low mid access", req_ready, 0);
    req_valid = 1'b0;
    end_burst();

    // R8: page change inside a chain and an idle gap on the same page
    scen = "R8";
    set_cfg(3, 1, 1'b0);
    send_req(24'h010004, 2'b11, 0);
    send_req(24'h010014, 2'b11, 1);
    send_req(24'h010016, 2'b11, 1);
    end_burst();
    send_req(24'h010018, 2'b11, 0);
    end_burst();

    // R6: first count shorter than in-page count
    scen = "R6";
    set_cfg(2, 6, 1'b0);
    send_req(24'h020000, 2'b11, 0);
    send_req(24'h020002, 2'b11, 1);
    send_req(24'h020004, 2'b11, 1);
    end_burst();

    // R7: zero counts give one-cycle accesses
    scen = "R7";
    set_cfg(0, 0, 1'b0);
    send_req(24'h030000, 2'b01, 0);
    send_req(24'h030002, 2'b10, 1);
    send_req(24'h030100, 2'b11, 1);
    end_burst();

    // R10: byte-select mode 1 drives all lanes
    scen = "R10 bat";
    set_cfg(3, 2, 1'b1);
    send_req(24'h040000, 2'b01, 0);
    send_req(24'h040002, 2'b10, 1);
    end_burst();

    // random bursts
    scen = "random";
    for (int b = 0; b < 60; b++) begin
      logic [AW-1:0] base;
      int n;
      set_cfg($urandom_range(0, 9), $urandom_range(0, 6), 1'($urandom_range(0, 1)));
      base = {4'h0, 4'($urandom_range(0, 3)), 12'($urandom), 4'h0};
      n = $urandom_range(1, 6);
      for (int i = 0; i < n; i++) begin
        if ($urandom_range(0, 3) == 0) base = {4'h0, 4'($urandom_range(0, 3)), 12'($urandom), 4'h0};
        send_req(base | AW'($urandom_range(0, 15)), 2'($urandom_range(0, 3)), i != 0);
      end
      end_burst();
    end

    chk(!r2_bad, "R2 strobes identical", r2_bad, 0);
    chk(rd_ptr == wr_ptr, "R9 all accesses completed", rd_ptr, wr_ptr);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule